// File: doc/BRIEF.md
# PLL scan-chain reconfiguration sequencer

This block reprograms a PLL at run time through its serial scan chain. When the user pulses `start` while the block is idle, it fetches a 144-bit configuration image from a small synchronous ROM in a single read. It then shifts the image into the PLL one bit per clock, highest index first, with the scan-clock enable held high for the whole shift and low at all other times.

After the last bit it leaves one quiet cycle and then strobes the configuration-update pin for one cycle. It then waits for the PLL to report completion by a rising edge on its scan-done pin. The scan-done level can stay high after an earlier reconfiguration, so only the rising edge counts as completion. The block finishes by pulsing the PLL reset for exactly one cycle, which lets the PLL relock, and then raises a one-cycle `done` pulse.

A programmable timeout bounds the wait for scan-done. If it expires, the sequence stops without any PLL reset and a sticky error flag is raised. All logic runs in the reconfiguration clock domain, and the PLL scan pins are assumed to be synchronous to that clock.

Top module: `pll_scan_seq`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, from the next cycle on `busy`, `done`, `timeout_err`, `rom_rd`, `scanclkena`, `scandata`, `configupdate` and `areset` are all 0, including when the reset arrives in the middle of a sequence.
- R2: A `start` sampled high while idle makes `rom_rd` high for exactly one cycle, the next cycle. `rom_data` is captured in the cycle after `rom_rd`, which means a one-cycle ROM latency. `busy` is high from the cycle after `start` until the sequence ends.
- R3: `scanclkena` is high for exactly 144 consecutive cycles per sequence, starting in the third cycle after the `start` edge.
- R4: In the k-th cycle of the shift (k = 0..143), `scandata` equals `rom_data[143-k]`, so bit 143 goes out first and bit 0 last.
- R5: `scandata` is 0 in every cycle in which `scanclkena` is 0, and `scanclkena` is only high while `busy` is high.
- R6: `configupdate` is high for exactly one cycle, the second cycle after the last `scanclkena` cycle, which leaves one cycle with neither pin high between them.
- R7: Completion is a `scandone` that is sampled low and then high, at any point from the cycle after `configupdate` on. A `scandone` that stays high is not taken as completion.
- R8: `areset` is high for exactly one cycle, namely the cycle after the first cycle in which the rising `scandone` is sampled high.
- R9: `done` is high for one cycle, the cycle after `areset`, and `busy` is low from the cycle after `done`.
- R10: Take `timeout_limit` = L. If no rising edge of `scandone` is seen within cycles 1 to L+1 after `configupdate`, then `timeout_err` rises and `busy` falls in cycle L+2 after `configupdate`, and neither `areset` nor `done` is raised. `timeout_err` stays high until the next accepted `start` clears it.
- R11: A `start` pulse while `busy` is high is ignored. The running sequence keeps its timing, and it produces one shift and one `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reconfiguration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a reconfiguration (sampled while idle) |
| timeout_limit | input | TMO_W | Scan-done wait limit in cycles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Sticky scan-done timeout flag |
| rom_rd | output | 1 | ROM read strobe |
| rom_data | input | CHAIN_LEN | Configuration image, valid one cycle after `rom_rd` |
| scandata | output | 1 | Serial configuration bit to the PLL |
| scanclkena | output | 1 | Scan clock enable to the PLL |
| configupdate | output | 1 | Configuration update strobe to the PLL |
| scandone | input | 1 | PLL scan completion indication |
| areset | output | 1 | PLL reset pulse |

## Verification
The assertions assume that `scandone` is synchronous to `clk` and that it does not rise in the same cycle as `configupdate`. They also assume that `timeout_limit` and the ROM word stay stable while a sequence runs. The bench drives every input on the falling edge. Its PLL model drops `scandone` when shifting begins and raises it only one or more cycles after the update strobe. The stuck-high and stuck-low cases are run as separate modes, and in both `scandone` produces no edge at all. The random images, delays and limits stay within these bounds, and the delay is pushed up to exactly the last accepted cycle.

// File: rtl/pll_scan_pkg.sv
// Package: shared types of the PLL scan sequencer.
// Assumes: nothing; it holds only the state encoding.
package pll_scan_pkg;

    // Sequencer phases, in the order in which they are visited.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CAPTURE,
        ST_SHIFT,
        ST_GAP,
        ST_UPDATE,
        ST_WAIT_DONE,
        ST_RESET_PULSE,
        ST_FINISH
    } seq_state_t;

endpackage

// File: rtl/pll_scan_shreg.sv
// Module: pll_scan_shreg
// Holds the configuration image and shifts it out MSB first, one bit
// per cycle in which shift_en is high. A down counter marks the last bit.
// Assumes: load and shift_en are never high together; a shift phase is
// always preceded by a load.
module pll_scan_shreg #(
    parameter int CHAIN_LEN = 144
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 shift_en,
    input  logic [CHAIN_LEN-1:0] image,
    output logic                 serial_bit,
    output logic                 last_bit
);
    localparam int CNT_W = $clog2(CHAIN_LEN);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CHAIN_LEN - 1);

    logic [CHAIN_LEN-1:0] shreg;
    logic [CNT_W-1:0]     bits_left;

    // Capture the image on load, otherwise move it one place towards the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= image;
        end else if (shift_en) begin
            shreg <= {shreg[CHAIN_LEN-2:0], 1'b0};
        end
    end

    // Count the bits still to be sent, reloading at the image capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_left <= '0;
        end else if (load) begin
            bits_left <= CNT_TOP;
        end else if (shift_en && bits_left != '0) begin
            bits_left <= bits_left - 1'b1;
        end
    end

    assign serial_bit = shreg[CHAIN_LEN-1];
    assign last_bit   = (bits_left == '0);

endmodule

// File: rtl/pll_scan_donemon.sv
// Module: pll_scan_donemon
// Watches the PLL scan-done pin for a rising edge and times the wait.
// Assumes: scandone is synchronous to clk. The previous value resets
// high so that a level which is already high is never taken for an edge.
module pll_scan_donemon #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scandone,
    input  logic             arm,
    input  logic             watch,
    input  logic [TMO_W-1:0] limit,
    output logic             rise,
    output logic             expired
);
    logic             done_prev;
    logic [TMO_W-1:0] wait_cnt;

    // Keep last cycle's scan-done level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_prev <= 1'b1;
        end else begin
            done_prev <= scandone;
        end
    end

    // Clear on arm, then count the watch cycles, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (arm) begin
            wait_cnt <= '0;
        end else if (watch && wait_cnt != {TMO_W{1'b1}}) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assign rise    = scandone & ~done_prev;
    assign expired = watch && (wait_cnt == limit);

endmodule

// File: rtl/pll_scan_fsm.sv
// Module: pll_scan_fsm
// Sequences fetch, shift, gap, update, wait, PLL reset and finish.
// It decodes the pin-level controls from the state register.
// Assumes: rise takes priority over expired in the same cycle.
module pll_scan_fsm
    import pll_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last_bit,
    input  logic rise,
    input  logic expired,
    output logic busy,
    output logic done,
    output logic timeout_err,
    output logic rom_rd,
    output logic load,
    output logic shift_en,
    output logic configupdate,
    output logic arm,
    output logic watch,
    output logic areset
);
    seq_state_t state, nxt;

    // Advance the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Choose the next phase.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:        if (start) nxt = ST_FETCH;
            ST_FETCH:       nxt = ST_CAPTURE;
            ST_CAPTURE:     nxt = ST_SHIFT;
            ST_SHIFT:       if (last_bit) nxt = ST_GAP;
            ST_GAP:         nxt = ST_UPDATE;
            ST_UPDATE:      nxt = ST_WAIT_DONE;
            ST_WAIT_DONE: begin
                if (rise)         nxt = ST_RESET_PULSE;
                else if (expired) nxt = ST_IDLE;
            end
            ST_RESET_PULSE: nxt = ST_FINISH;
            ST_FINISH:      nxt = ST_IDLE;
            default:        nxt = ST_IDLE;
        endcase
    end

    // Sticky timeout flag, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_err <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            timeout_err <= 1'b0;
        end else if (state == ST_WAIT_DONE && !rise && expired) begin
            timeout_err <= 1'b1;
        end
    end

    assign busy         = (state != ST_IDLE);
    assign rom_rd       = (state == ST_FETCH);
    assign load         = (state == ST_CAPTURE);
    assign shift_en     = (state == ST_SHIFT);
    assign configupdate = (state == ST_UPDATE);
    assign arm          = (state == ST_UPDATE);
    assign watch        = (state == ST_WAIT_DONE);
    assign areset       = (state == ST_RESET_PULSE);
    assign done         = (state == ST_FINISH);

endmodule

// File: rtl/pll_scan_seq.sv
// Module: pll_scan_seq (top)
// Reconfigures a PLL through its serial scan chain: ROM fetch, MSB-first
// shift, update strobe, scan-done edge wait with timeout, one-cycle reset.
// Assumes: the ROM returns data one cycle after rom_rd, and all PLL scan
// pins share clk.
module pll_scan_seq #(
    parameter int CHAIN_LEN = 144,
    parameter int TMO_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [TMO_W-1:0]     timeout_limit,
    output logic                 busy,
    output logic                 done,
    output logic                 timeout_err,
    output logic                 rom_rd,
    input  logic [CHAIN_LEN-1:0] rom_data,
    output logic                 scandata,
    output logic                 scanclkena,
    output logic                 configupdate,
    input  logic                 scandone,
    output logic                 areset
);
    logic load, shift_en, last_bit, serial_bit;
    logic arm, watch, rise, expired;

    pll_scan_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .last_bit     (last_bit),
        .rise         (rise),
        .expired      (expired),
        .busy         (busy),
        .done         (done),
        .timeout_err  (timeout_err),
        .rom_rd       (rom_rd),
        .load         (load),
        .shift_en     (shift_en),
        .configupdate (configupdate),
        .arm          (arm),
        .watch        (watch),
        .areset       (areset)
    );

    pll_scan_shreg #(.CHAIN_LEN(CHAIN_LEN)) u_shreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .shift_en   (shift_en),
        .image      (rom_data),
        .serial_bit (serial_bit),
        .last_bit   (last_bit)
    );

    pll_scan_donemon #(.TMO_W(TMO_W)) u_donemon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scandone (scandone),
        .arm      (arm),
        .watch    (watch),
        .limit    (timeout_limit),
        .rise     (rise),
        .expired  (expired)
    );

    assign scanclkena = shift_en;
    assign scandata   = serial_bit & shift_en;

endmodule

// File: rtl/pll_scan_seq_chk.sv
// Module: pll_scan_seq_chk
// Protocol checks on the pins of pll_scan_seq, attached by bind.
// Assumes: scandone is synchronous to clk.
module pll_scan_seq_chk #(
    parameter int CHAIN_LEN = 144
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic timeout_err,
    input logic rom_rd,
    input logic scandata,
    input logic scanclkena,
    input logic configupdate,
    input logic scandone,
    input logic areset
);
    localparam int RUN_W = $clog2(CHAIN_LEN + 1) + 1;

    logic [RUN_W-1:0] ena_run;

    // Length of the current run of scan-enable cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)          ena_run <= '0;
        else if (scanclkena) ena_run <= ena_run + 1'b1;
        else                 ena_run <= '0;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !rom_rd && !scanclkena && !configupdate && !areset));

    p_start_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> rom_rd);

    p_fetch_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |=> !rom_rd);

    p_shift_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scanclkena) && $past(rst_n)) |-> (ena_run == RUN_W'(CHAIN_LEN)));

    p_data_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !scanclkena |-> !scandata);

    p_ena_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        scanclkena |-> busy);

    p_gap_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scanclkena) && $past(rst_n)) |-> (!configupdate ##1 configupdate));

    p_update_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        configupdate |=> !configupdate);

    p_reset_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(areset) |-> $past(scandone));

    p_reset_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        areset |=> !areset);

    p_done_after_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(areset));

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_timeout_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (!busy && !areset));

    p_pins_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scanclkena, configupdate, areset, done}));

endmodule

bind pll_scan_seq pll_scan_seq_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .timeout_err  (timeout_err),
    .rom_rd       (rom_rd),
    .scandata     (scandata),
    .scanclkena   (scanclkena),
    .configupdate (configupdate),
    .scandone     (scandone),
    .areset       (areset)
);

// File: tb/pll_scan_seq_tb_top.sv
// Bench for pll_scan_seq: a ROM model, a cycle-level PLL scan-done model,
// random images, delays and limits, plus directed corner cases.
module pll_scan_seq_tb_top;
    localparam int N = 144;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [15:0]  tmo = 16'd0;
    logic         busy, done, timeout_err, rom_rd;
    logic [N-1:0] rom_img = '0;
    logic [N-1:0] rom_q = '0;
    logic         scandata, scanclkena, configupdate, areset;
    logic         scandone = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    // Synchronous ROM with one cycle of latency.
    always @(posedge clk) if (rom_rd) rom_q <= rom_img;

    pll_scan_seq #(.CHAIN_LEN(N), .TMO_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .timeout_limit(tmo),
        .busy(busy), .done(done), .timeout_err(timeout_err), .rom_rd(rom_rd),
        .rom_data(rom_q), .scandata(scandata), .scanclkena(scanclkena),
        .configupdate(configupdate), .scandone(scandone), .areset(areset)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // The run succeeds only with a real edge inside the window.
    function automatic bit expect_ok(input int mode, input int delay, input int limit);
        return (mode == 0) && (delay >= 1) && (delay <= limit + 1);
    endfunction

    function automatic logic [N-1:0] rand_img();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = 1'($urandom % 2);
        return v;
    endfunction

    // mode 0: scandone drops at shift, rises delay cycles after update
    // mode 1: scandone held high throughout; mode 2: held low after shift
    task automatic run_seq(input logic [N-1:0] img, input int delay, input int limit,
                           input int mode, input bit midstart);
        int t = 1;
        int rd_cnt = 0, rd_t = -1, ena_cnt = 0, f_ena = -1, l_ena = -1;
        int cfg_cnt = 0, cfg_t = -1000, ar_cnt = 0, ar_t = -1, dn_cnt = 0, dn_t = -1;
        int err_t = -1, end_t = -1, viol = 0, mism = 0;
        logic [N-1:0] cap = '0;
        rom_img = img;
        tmo = 16'(limit);
        if (mode == 1) scandone = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(timeout_err == 1'b0, "R10", int'(timeout_err), 0);
        forever begin
            if (rom_rd) begin rd_cnt++; rd_t = t; end
            if (scanclkena) begin
                ena_cnt++;
                if (f_ena < 0) f_ena = t;
                l_ena = t;
                cap = {cap[N-2:0], scandata};
            end else if (scandata) viol++;
            if (configupdate) begin cfg_cnt++; cfg_t = t; end
            if (areset) begin ar_cnt++; ar_t = t; end
            if (done) begin dn_cnt++; dn_t = t; end
            if (timeout_err && err_t < 0) err_t = t;
            if (!busy) begin end_t = t; break; end
            if (t > 3000) break;
            if (mode != 1 && scanclkena) scandone = 1'b0;
            if (mode == 0 && t == cfg_t + delay) scandone = 1'b1;
            start = midstart && (t == 50);
            @(negedge clk);
            t++;
        end
        for (int i = 0; i < N; i++) if (cap[i] !== img[i]) mism++;
        chk(rd_cnt == 1 && rd_t == 1, "R2", rd_t, 1);
        chk(ena_cnt == N && f_ena == 3 && l_ena - f_ena == N - 1, midstart ? "R11" : "R3", ena_cnt, N);
        chk(mism == 0, "R4", mism, 0);
        chk(viol == 0, "R5", viol, 0);
        chk(cfg_cnt == 1 && cfg_t == l_ena + 2, "R6", cfg_t, l_ena + 2);
        if (expect_ok(mode, delay, limit)) begin
            chk(ar_cnt == 1 && ar_t == cfg_t + delay + 1, mode == 0 ? "R8" : "R7", ar_t, cfg_t + delay + 1);
            chk(dn_cnt == 1 && dn_t == ar_t + 1, midstart ? "R11" : "R9", dn_t, ar_t + 1);
            chk(end_t == dn_t + 1, "R9", end_t, dn_t + 1);
            chk(err_t < 0, "R10", err_t, -1);
        end else begin
            chk(err_t == cfg_t + limit + 2, mode == 0 ? "R10" : "R7", err_t, cfg_t + limit + 2);
            chk(ar_cnt == 0 && dn_cnt == 0, "R10", ar_cnt + dn_cnt, 0);
            chk(end_t == err_t, "R10", end_t, err_t);
        end
        @(negedge clk);
    endtask

    task automatic quiet_check(input string req);
        chk(!busy && !done && !timeout_err && !rom_rd && !scanclkena && !scandata
            && !configupdate && !areset, req,
            int'({busy, done, timeout_err, rom_rd, scanclkena, scandata, configupdate, areset}), 0);
    endtask

    // Watchdog: a hung run ends as a failure with the summary line.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        quiet_check("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: ends of the image set, fastest scan-done.
        run_seq({1'b1, {(N-2){1'b0}}, 1'b1}, 1, 10, 0, 1'b0);
        run_seq({(N/2){2'b01}}, 3, 5, 0, 1'b0);
        // Boundary: edge in the last accepted cycle, and one cycle late.
        run_seq(rand_img(), 5, 4, 0, 1'b0);
        run_seq(rand_img(), 6, 4, 0, 1'b0);
        // Sticky error, then cleared by the next start (checked inside).
        repeat (3) @(negedge clk);
        chk(timeout_err == 1'b1, "R10", int'(timeout_err), 1);
        // Zero limit: only the first wait cycle counts.
        run_seq(rand_img(), 1, 0, 0, 1'b0);
        // Level held high is not completion.
        run_seq(rand_img(), 1, 7, 1, 1'b0);
        // No edge at all.
        run_seq(rand_img(), 1, 3, 2, 1'b0);
        // Start while busy is ignored.
        run_seq(rand_img(), 4, 8, 0, 1'b1);

        // Reset in the middle of the shift.
        rom_img = rand_img();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        quiet_check("R1");
        rst_n = 1'b1;
        scandone = 1'b0;
        @(negedge clk);

        // Random mix.
        for (int k = 0; k < 14; k++) begin
            int lim = int'($urandom % 20);
            int dly = 1 + int'($urandom % 23);
            run_seq(rand_img(), dly, lim, 0, 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule